// File: doc/BRIEF.md
# Feature Switch Bank Behind the Cycle Counter Address

This block holds a set of single-bit, chip-wide feature switches. The switches are written by storing to the register address of the free-running cycle counter. Existing software only ever reads that address, so the store slot is free to reuse. A read of the same address still returns the running count. Stores there never disturb the counter.

Each store selects and sets exactly one switch. Data bit 0 is the new switch value. Data bits 31:1 are the switch number. Only `NSW` switches exist in hardware (64 by default). Any store whose switch number is `NSW` or above changes nothing. With the default of 64, that means data bits 31:7 must be zero for a store to take effect.

Several cores present stores in parallel. A fixed-priority arbiter picks at most one store per cycle. Each switch drives a chip-wide enable, for example one that gives up boot ROM space in exchange for extra shared RAM. All switches clear to 0 at reset, which selects full legacy behaviour.

Top module: `feature_switch_bank`

## Requirements
- R1: While `rst` is high, every bit of `feat_en_o` is 0, `cnt_o` is 0 and `rd_data_o` is 0. These values are seen on the cycle after the first reset edge.
- R2: After reset, `cnt_o` rises by exactly one on every clock edge and wraps at 2^32. Stores to the counter address never change it.
- R3: `rd_data_o` is registered. When `rd_addr_i` equals `CNT_ADDR`, `rd_data_o` shows one edge later the value `cnt_o` had when that address was sampled. For any other address it shows 0.
- R4: A store from core c (request bit c, address slice c and data slice c) to `CNT_ADDR` with data bits 31:7 all zero sets switch number data[6:1] to data[0]. The new value appears on `feat_en_o` (bit n for switch n) right after the clock edge that samples the store.
- R5: A store to `CNT_ADDR` whose data bits 31:1, read as a number, are 64 or more is ignored. No switch changes.
- R6: A store to any address other than `CNT_ADDR` leaves every switch unchanged.
- R7: When several cores store to `CNT_ADDR` in the same cycle, only the lowest-numbered of them is considered. The stores of the other cores are dropped, even if the winning store is then ignored because it is out of range.
- R8: At most one bit of `feat_en_o` changes per clock edge. Every switch that is not addressed by the accepted store keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | NCORE | One store request per core |
| wr_addr_i | input | NCORE*AW | Store addresses; core c uses bits c*AW +: AW |
| wr_data_i | input | NCORE*DW | Store data; core c uses bits c*DW +: DW |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Registered read data (counter value or zero) |
| cnt_o | output | DW | Free-running cycle counter |
| feat_en_o | output | NSW | Chip-wide feature enables, one per switch |

## Verification
The counter read-back and a switch store can land in the same cycle. A switch store and competing stores from other cores can also land in the same cycle. The bench holds `rd_addr_i` on the counter address while it issues stores there. In those cycles it checks that `cnt_o` and `rd_data_o` keep to their one-per-cycle sequence. It also loads every core with a store in one cycle, mixing in-range and out-of-range data and other addresses. A behavioural model then decides on every edge which single store, if any, takes effect, and all 64 enables are compared against it.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Accepted store after arbitration
  typedef struct packed {
    logic  vld;
    word_t data;
  } win_t;
endpackage

// File: rtl/fsw_counter.sv
module fsw_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fsw_arbiter.sv
module fsw_arbiter
  import fsw_pkg::*;
#(
  parameter int          NCORE    = 4,
  parameter int          AW       = 9,
  parameter logic [AW-1:0] CNT_ADDR = 9'h1F1
) (
  input  logic [NCORE-1:0]        req_i,
  input  logic [NCORE*AW-1:0]     addr_i,
  input  logic [NCORE*WORD_W-1:0] data_i,
  output logic [NCORE-1:0]        grant_o,
  output win_t                    win_o
);
  logic [NCORE-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NCORE; g++) begin : g_hit
      assign hit[g] = req_i[g] && (addr_i[g*AW +: AW] == CNT_ADDR);
    end
  endgenerate

  // Lowest-numbered hit wins: scan downward so the lowest overrides
  always_comb begin
    grant_o = '0;
    win_o   = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (hit[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        win_o.vld  = 1'b1;
        win_o.data = data_i[i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/fsw_decode.sv
module fsw_decode
  import fsw_pkg::*;
#(
  parameter int NSW  = 64,
  parameter int IDXW = (NSW > 1) ? $clog2(NSW) : 1
) (
  input  win_t            win_i,
  output logic            we_o,
  output logic [IDXW-1:0] idx_o,
  output logic            val_o
);
  logic [WORD_W-2:0] sel;
  logic              in_range;

  assign sel      = win_i.data[WORD_W-1:1];
  assign in_range = (sel < (WORD_W-1)'(NSW));
  assign we_o     = win_i.vld && in_range;
  assign idx_o    = sel[IDXW-1:0];
  assign val_o    = win_i.data[0];
endmodule

// File: rtl/fsw_bank.sv
module fsw_bank #(
  parameter int NSW  = 64,
  parameter int IDXW = (NSW > 1) ? $clog2(NSW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            val_i,
  output logic [NSW-1:0]  sw_o
);
  logic [NSW-1:0] sw_q;

  genvar g;
  generate
    for (g = 0; g < NSW; g++) begin : g_sw
      always_ff @(posedge clk) begin
        if (rst)                                    sw_q[g] <= 1'b0;
        else if (we_i && (idx_i == IDXW'(g)))       sw_q[g] <= val_i;
      end
    end
  endgenerate

  assign sw_o = sw_q;
endmodule

// File: rtl/feature_switch_bank.sv
module feature_switch_bank
  import fsw_pkg::*;
#(
  parameter int            NCORE    = 4,
  parameter int            AW       = 9,
  parameter int            DW       = WORD_W,
  parameter int            NSW      = 64,
  parameter logic [AW-1:0] CNT_ADDR = 9'h1F1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCORE-1:0]     wr_req_i,
  input  logic [NCORE*AW-1:0]  wr_addr_i,
  input  logic [NCORE*DW-1:0]  wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DW-1:0]        rd_data_o,
  output logic [DW-1:0]        cnt_o,
  output logic [NSW-1:0]       feat_en_o
);
  localparam int IDXW = (NSW > 1) ? $clog2(NSW) : 1;

  logic [NCORE-1:0] grant;
  win_t             win;
  logic             dec_we;
  logic [IDXW-1:0]  dec_idx;
  logic             dec_val;
  logic [DW-1:0]    cnt;
  logic [DW-1:0]    rd_q;

  fsw_counter #(.CW(DW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  fsw_arbiter #(.NCORE(NCORE), .AW(AW), .CNT_ADDR(CNT_ADDR)) u_arb (
    .req_i   (wr_req_i),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .grant_o (grant),
    .win_o   (win)
  );

  fsw_decode #(.NSW(NSW), .IDXW(IDXW)) u_dec (
    .win_i (win),
    .we_o  (dec_we),
    .idx_o (dec_idx),
    .val_o (dec_val)
  );

  fsw_bank #(.NSW(NSW), .IDXW(IDXW)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we_i  (dec_we),
    .idx_i (dec_idx),
    .val_i (dec_val),
    .sw_o  (feat_en_o)
  );

  // Read path: the counter address keeps returning the count
  always_ff @(posedge clk) begin
    if (rst)                        rd_q <= '0;
    else if (rd_addr_i == CNT_ADDR) rd_q <= cnt;
    else                            rd_q <= '0;
  end

  assign rd_data_o = rd_q;
  assign cnt_o     = cnt;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int            NCORE    = 4,
  parameter int            AW       = 9,
  parameter int            DW       = 32,
  parameter int            NSW      = 64,
  parameter logic [AW-1:0] CNT_ADDR = 9'h1F1
) (
  input logic             clk,
  input logic             rst,
  input logic [NSW-1:0]   feat,
  input logic [DW-1:0]    cnt,
  input logic [AW-1:0]    rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic [NCORE-1:0] grant,
  input logic             we
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (feat == '0) && (cnt == '0) && (rd_data == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + DW'(1)));

  // R3
  count_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_addr) == CNT_ADDR)) |-> (rd_data == $past(cnt)));

  // R5
  ignored_store_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(feat));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R8
  one_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(feat ^ $past(feat)) <= 1));
endmodule

bind feature_switch_bank fsw_checker #(
  .NCORE(NCORE), .AW(AW), .DW(DW), .NSW(NSW), .CNT_ADDR(CNT_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .feat    (feat_en_o),
  .cnt     (cnt_o),
  .rd_addr (rd_addr_i),
  .rd_data (rd_data_o),
  .grant   (grant),
  .we      (dec_we)
);

// File: tb/feature_switch_bank_test.sv
`timescale 1ns/1ps
module feature_switch_bank_test;
  localparam int            NCORE = 4;
  localparam int            AW    = 9;
  localparam int            DW    = 32;
  localparam int            NSW   = 64;
  localparam logic [AW-1:0] CA    = 9'h1F1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NCORE-1:0]    req = '0;
  logic [NCORE*AW-1:0] addr = '0;
  logic [NCORE*DW-1:0] data = '0;
  logic [AW-1:0]       rd_addr = '0;
  logic [DW-1:0]       rd_data;
  logic [DW-1:0]       cnt;
  logic [NSW-1:0]      feat;

  // Reference model
  logic [NSW-1:0] m_sw  = '0;
  logic [DW-1:0]  m_cnt = '0;
  logic [DW-1:0]  m_rd  = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  feature_switch_bank #(.NCORE(NCORE), .AW(AW), .DW(DW), .NSW(NSW), .CNT_ADDR(CA)) uut (
    .clk(clk), .rst(rst), .wr_req_i(req), .wr_addr_i(addr), .wr_data_i(data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cnt_o(cnt), .feat_en_o(feat)
  );

  function automatic logic [DW-1:0] mk(input int idx, input bit v);
    logic [DW-1:0] w;
    w = DW'(idx) << 1;
    w[0] = v;
    return w;
  endfunction

  task automatic put(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req[c] = 1'b1;
    addr[c*AW +: AW] = a;
    data[c*DW +: DW] = d;
  endtask

  task automatic idle();
    req = '0;
  endtask

  task automatic model_edge();
    if (rst) begin
      m_sw = '0; m_cnt = '0; m_rd = '0;
    end else begin
      m_rd = (rd_addr == CA) ? m_cnt : '0;
      m_cnt = m_cnt + 1;
      for (int c = 0; c < NCORE; c++) begin
        if (req[c] && addr[c*AW +: AW] == CA) begin
          logic [DW-1:0] d;
          d = data[c*DW +: DW];
          if ((d >> 1) < NSW) m_sw[d[6:1]] = d[0];
          break;
        end
      end
    end
  endtask

  task automatic cmp(input string tag, input logic [NSW-1:0] act, input logic [NSW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag, feat, m_sw);
    cmp(rst ? "R1" : "R2", NSW'(cnt), NSW'(m_cnt));
    cmp(rst ? "R1" : "R3", NSW'(rd_data), NSW'(m_rd));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rd_addr = CA;
    // R1 reset state
    repeat (3) step("R1");
    @(negedge clk); rst = 1'b0;
    repeat (3) step("R2");
    // R3 read of other addresses returns zero, then counter again
    rd_addr = CA ^ 9'h001; repeat (2) step("R3");
    rd_addr = CA;          repeat (2) step("R3");
    // R4 directed stores while counter is being read
    put(0, CA, mk(0, 1));  step("R4"); idle();
    put(2, CA, mk(63, 1)); step("R4"); idle();
    put(1, CA, mk(17, 1)); step("R4"); idle();
    put(3, CA, mk(17, 0)); step("R4"); idle();
    step("R4");
    // R5 out-of-range stores
    put(0, CA, 32'h8000_000B); step("R5"); idle();
    put(0, CA, mk(64, 1));     step("R5"); idle();
    put(1, CA, mk(127, 1));    step("R5"); idle();
    // R6 store elsewhere
    put(0, CA ^ 9'h010, mk(5, 1)); step("R6"); idle();
    put(3, 9'h000, mk(6, 1));      step("R6"); idle();
    // R7 competing stores: core 1 wins
    put(3, CA, mk(30, 1)); put(2, CA, mk(31, 1)); put(1, CA, mk(32, 1));
    step("R7"); idle();
    // R7 winner out of range drops the others
    put(0, CA, mk(70, 1)); put(2, CA, mk(40, 1));
    step("R7"); idle();
    // R7 lower core at other address does not block
    put(0, 9'h010, mk(41, 1)); put(3, CA, mk(42, 1));
    step("R7"); idle();
    // R8 random mix
    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < NCORE; c++) begin
        req[c] = ($urandom_range(0, 2) == 0);
        addr[c*AW +: AW] = ($urandom_range(0, 4) == 0) ? AW'($urandom) : CA;
        data[c*DW +: DW] = ($urandom_range(0, 5) == 0) ? $urandom
                                                        : mk($urandom_range(0, 80), 1'($urandom));
      end
      rd_addr = ($urandom_range(0, 3) == 0) ? AW'($urandom) : CA;
      step("R8");
    end
    idle();
    step("R8");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule